// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block moves outgoing frames from memory onto a byte stream. Software places transmit descriptors in a ring in memory. Each descriptor is 8 bytes in little-endian order: bytes 0..3 hold the fragment's buffer address, bytes 4..5 hold a length field, and bytes 6..7 hold the flags. Software then writes a start command to the control input. The engine walks the ring from its current index. It copies each fragment into an internal staging buffer and keeps filling that buffer until a descriptor marked as the final fragment arrives. At that point it emits the buffer contents as one frame on a valid/ready output stream.

After each descriptor has been handled, the engine writes its flag bytes back to memory. The write-back clears the ownership bit and the transmit error bits and leaves every other flag bit as it was. A fragment that would not fit in the staging buffer is never fetched. Instead its descriptor is written back with error bits set, and the partial frame is dropped. When a walk has sent at least one frame, the engine raises a one-cycle interrupt pulse. An idle output shows whether a walk is running. A reset command returns the ring index and the staging fill level to zero.

Memory reads are byte-wide. A request moves when `mem_rd_valid` and `mem_rd_ready` are both high. Its data returns on a later cycle flagged by `mem_rsp_valid`. Only one read is outstanding at a time. Writes move when `mem_wr_valid` and `mem_wr_ready` are both high. On all three request channels (memory read, memory write and frame output), the engine holds valid, address and data steady until the other side accepts them. The frame output moves one byte per cycle in which `tx_valid` and `tx_ready` are both high. A low `tx_ready` stalls the output indefinitely and loses no data.

Top module: `tx_gather`

## Requirements
- R1: A walk starts only when `ctrl_wr` is high and `ctrl_wdata` equals exactly 32'h0000_0001. Any other written value starts nothing, including values that contain bit 0 together with other bits.
- R2: The descriptor at ring index i is read from address `ring_base + 8*i`. Its bytes are little-endian: address in bytes 0..3, length in bytes 4..5, flags in bytes 6..7.
- R3: The walk stops at the first descriptor whose flag bit 15 (owned/valid) is clear. That descriptor is not written back, and the ring index does not move past it.
- R4: A valid descriptor's fragment is length+1 bytes, read from its buffer address. It is appended to the staging buffer at the current fill level, and the fill level then grows by length+1.
- R5: Each processed descriptor has its flag bytes written back to addresses +6 and +7. Bits 15..9 (valid, generic error, underflow, late collision, carrier lost, deferred, retry error) are cleared. Bits 8..0 are unchanged.
- R6: A processed descriptor with flag bit 0 (last fragment) set sends the whole staging buffer as one frame, with `tx_last` on its final byte. The fill level then returns to zero, and the walk ends after that descriptor's write-back.
- R7: A fragment whose length+1 would take the fill level above MAX_FRAME+128 bytes is not fetched. Its write-back sets bits 14 and 13 in place of the cleared error bits. The frame gathered so far is dropped, and the fill level returns to zero.
- R8: `tx_irq` pulses for one cycle when a walk ends, and only if that walk sent at least one frame.
- R9: `idle` is high out of reset and between walks, and it is low from the cycle after the start command until the walk ends. Writing a value with bit 2 set while idle sets the ring index and the fill level to zero.
- R10: A walk processes at most `ring_size` descriptors. The index wraps from `ring_size`-1 to 0.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write value (start command or reset bit) |
| ring_base | input | 32 | Byte address of ring entry 0 |
| ring_size | input | IDX_W | Number of descriptors in the ring |
| mem_rd_valid | output | 1 | Byte read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| mem_wr_valid | output | 1 | Byte write request valid |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts the frame byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| idle | output | 1 | No walk in progress |
| tx_irq | output | 1 | One-cycle pulse: a walk that sent a frame has ended |
| ring_index | output | IDX_W | Current ring index |

## Verification
A wrong ring index shows up at once: the next walk fetches from the wrong descriptor address, and the written-back flags land at the wrong place in memory. A fill level that is not reset correctly shows up on the next frame, which comes out too long or with stale leading bytes. Every test therefore compares whole frames byte by byte and checks the exact write-back bytes and the final index after each walk. A faulty stall path shows up as duplicated or missing bytes when `tx_ready` toggles, which the gather test exercises.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;

  typedef enum logic [3:0] {
    W_IDLE, W_DREQ, W_DWAIT, W_CHECK, W_FREQ, W_FWAIT,
    W_WB_LO, W_WB_HI, W_EMIT, W_NEXT, W_DONE
  } walk_st_e;

  // In-memory descriptor image, byte 0 in the low bits.
  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
    logic [31:0] buf_addr;
  } tx_desc_t;

  localparam logic [31:0] START_CODE   = 32'h0000_0001;
  localparam int          CLR_BIT      = 2;
  localparam int          FLAG_OWN     = 15;
  localparam int          FLAG_LAST    = 0;
  localparam logic [15:0] WB_CLR_MASK  = 16'hFE00;
  localparam logic [15:0] WB_OVF_SET   = 16'h6000;

endpackage

// File: rtl/tx_stage_buf.sv
module tx_stage_buf #(
  parameter int DEPTH = 1642,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

  // R7: the walker never writes past the end of the staging store
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/tx_frame_emit.sv
module tx_frame_emit #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] rd_addr,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          done
);
  logic          active;
  logic [AW-1:0] ptr;
  logic [AW-1:0] end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      end_q  <= '0;
    end else if (go) begin
      active <= 1'b1;
      ptr    <= '0;
      end_q  <= len - AW'(1);
    end else if (active && tx_ready) begin
      if (ptr == end_q) active <= 1'b0;
      else              ptr    <= ptr + AW'(1);
    end
  end

  assign rd_addr  = ptr;
  assign tx_valid = active;
  assign tx_last  = active && (ptr == end_q);
  assign done     = active && tx_ready && (ptr == end_q);

  // R11: a stalled beat keeps its position and its end marker
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(rd_addr) && $stable(tx_last)));
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_gather_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 1642,
  parameter int OFF_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W-1:0] ring_size,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rsp_data,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [31:0]      mem_wr_addr,
  output logic [7:0]       mem_wr_data,
  output logic             stg_we,
  output logic [OFF_W-1:0] stg_waddr,
  output logic [7:0]       stg_wdata,
  output logic             emit_go,
  output logic [OFF_W-1:0] emit_len,
  input  logic             emit_done,
  output logic             idle,
  output logic             tx_irq,
  output logic [IDX_W-1:0] ring_index
);
  walk_st_e         st;
  tx_desc_t         desc_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   visited;
  logic [2:0]       bcnt;
  logic [16:0]      fcnt;
  logic [OFF_W-1:0] fill_off;
  logic             ovf;
  logic             sent;

  logic [31:0]      desc_addr;
  logic [16:0]      frag_len;
  logic [17:0]      fill_end;
  logic             fits;
  logic [IDX_W:0]   idx_inc;
  logic [IDX_W-1:0] idx_nxt;
  logic [15:0]      wb_flags;
  logic             is_last;
  logic             start_cmd;
  logic             clr_cmd;

  assign desc_addr = ring_base + {{(32-IDX_W-3){1'b0}}, idx, 3'b000};
  assign frag_len  = {1'b0, desc_q.len} + 17'd1;
  assign fill_end  = 18'(fill_off) + 18'(frag_len);
  assign fits      = (fill_end <= 18'(BUF_BYTES));
  assign idx_inc   = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
  assign idx_nxt   = (idx_inc >= {1'b0, ring_size}) ? '0 : idx_inc[IDX_W-1:0];
  assign is_last   = desc_q.flags[FLAG_LAST];
  assign wb_flags  = ovf ? ((desc_q.flags & ~WB_CLR_MASK) | WB_OVF_SET)
                         : (desc_q.flags & ~WB_CLR_MASK);
  assign start_cmd = ctrl_wr && (ctrl_wdata == START_CODE);
  assign clr_cmd   = ctrl_wr && ctrl_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      desc_q   <= '0;
      idx      <= '0;
      visited  <= '0;
      bcnt     <= '0;
      fcnt     <= '0;
      fill_off <= '0;
      ovf      <= 1'b0;
      sent     <= 1'b0;
      emit_go  <= 1'b0;
      emit_len <= '0;
      tx_irq   <= 1'b0;
    end else begin
      emit_go <= 1'b0;
      tx_irq  <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (start_cmd) begin
            visited <= '0;
            sent    <= 1'b0;
            bcnt    <= '0;
            st      <= (ring_size == '0) ? W_DONE : W_DREQ;
          end else if (clr_cmd) begin
            idx      <= '0;
            fill_off <= '0;
          end
        end
        W_DREQ:  if (mem_rd_ready) st <= W_DWAIT;
        W_DWAIT: if (mem_rsp_valid) begin
          desc_q <= {mem_rsp_data, desc_q[63:8]};
          bcnt   <= bcnt + 3'd1;
          st     <= (bcnt == 3'd7) ? W_CHECK : W_DREQ;
        end
        W_CHECK: begin
          if (!desc_q.flags[FLAG_OWN]) begin
            st <= W_DONE;
          end else begin
            visited <= visited + 1'b1;
            fcnt    <= '0;
            ovf     <= !fits;
            st      <= fits ? W_FREQ : W_WB_LO;
          end
        end
        W_FREQ:  if (mem_rd_ready) st <= W_FWAIT;
        W_FWAIT: if (mem_rsp_valid) begin
          if (fcnt + 17'd1 == frag_len) begin
            fill_off <= OFF_W'(fill_end);
            st       <= W_WB_LO;
          end else begin
            fcnt <= fcnt + 17'd1;
            st   <= W_FREQ;
          end
        end
        W_WB_LO: if (mem_wr_ready) st <= W_WB_HI;
        W_WB_HI: if (mem_wr_ready) begin
          idx <= idx_nxt;
          if (ovf) fill_off <= '0;
          if (is_last) begin
            if (ovf) begin
              st <= W_DONE;
            end else begin
              emit_go  <= 1'b1;
              emit_len <= fill_off;
              fill_off <= '0;
              sent     <= 1'b1;
              st       <= W_EMIT;
            end
          end else begin
            st <= W_NEXT;
          end
        end
        W_EMIT: if (emit_done) st <= W_DONE;
        W_NEXT: begin
          bcnt <= '0;
          st   <= (visited >= {1'b0, ring_size}) ? W_DONE : W_DREQ;
        end
        W_DONE: begin
          tx_irq <= sent;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (st == W_DREQ) || (st == W_FREQ);
  assign mem_rd_addr  = (st == W_DREQ) ? (desc_addr + 32'(bcnt))
                                       : (desc_q.buf_addr + 32'(fcnt));
  assign mem_wr_valid = (st == W_WB_LO) || (st == W_WB_HI);
  assign mem_wr_addr  = desc_addr + ((st == W_WB_HI) ? 32'd7 : 32'd6);
  assign mem_wr_data  = (st == W_WB_HI) ? wb_flags[15:8] : wb_flags[7:0];
  assign stg_we       = (st == W_FWAIT) && mem_rsp_valid;
  assign stg_waddr    = fill_off + OFF_W'(fcnt);
  assign stg_wdata    = mem_rsp_data;
  assign idle         = (st == W_IDLE);
  assign ring_index   = idx;

  // R2: a pending read keeps its address until accepted
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  // R5: the high flag byte written back never carries the owned bit
  a_r5_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_addr == desc_addr + 32'd7) |-> !mem_wr_data[7]);
  // R9: no memory traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mem_rd_valid && !mem_wr_valid));
  // R8: the interrupt pulse is followed by idle
  a_r8_irq_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> (idle && !tx_irq));
  // R10: never more descriptors than the ring holds
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (visited <= {1'b0, ring_size}));
endmodule

// File: rtl/tx_gather.sv
module tx_gather #(
  parameter int MAX_FRAME = 1514,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W-1:0] ring_size,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rsp_data,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [31:0]      mem_wr_addr,
  output logic [7:0]       mem_wr_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             idle,
  output logic             tx_irq,
  output logic [IDX_W-1:0] ring_index
);
  localparam int BUF_BYTES = MAX_FRAME + 128;
  localparam int OFF_W     = $clog2(BUF_BYTES + 1);

  logic             stg_we;
  logic [OFF_W-1:0] stg_waddr;
  logic [7:0]       stg_wdata;
  logic [OFF_W-1:0] stg_raddr;
  logic             emit_go;
  logic [OFF_W-1:0] emit_len;
  logic             emit_done;

  tx_ring_walker #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_walk (
    .clk, .rst_n, .ctrl_wr, .ctrl_wdata, .ring_base, .ring_size,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data,
    .stg_we, .stg_waddr, .stg_wdata,
    .emit_go, .emit_len, .emit_done,
    .idle, .tx_irq, .ring_index
  );

  tx_stage_buf #(.DEPTH(BUF_BYTES), .AW(OFF_W)) u_stage (
    .clk, .rst_n, .we(stg_we), .waddr(stg_waddr), .wdata(stg_wdata),
    .raddr(stg_raddr), .rdata(tx_data)
  );

  tx_frame_emit #(.AW(OFF_W)) u_emit (
    .clk, .rst_n, .go(emit_go), .len(emit_len), .rd_addr(stg_raddr),
    .tx_valid, .tx_ready, .tx_last, .done(emit_done)
  );
endmodule

// File: tb/tx_gather_bench.sv
module tx_gather_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 64;
  localparam int BUFB = MAXF + 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ring_base = 32'h100;
  logic [7:0]  ring_size = 8'd4;
  logic        mem_rd_valid, mem_rd_ready = 1'b1;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0]  tx_data;
  logic        idle, tx_irq;
  logic [7:0]  ring_index;

  tx_gather #(.MAX_FRAME(MAXF), .IDX_W(8)) u_tx_gather (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [4096];
  logic [7:0] cap [1024];
  int cap_n = 0, frames = 0, irqs = 0, cyc = 0;
  bit stall = 0;
  logic [7:0] expb [256];
  int exp_n;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
    mem_rsp_data  <= mem[mem_rd_addr[11:0]];
    if (mem_wr_valid && mem_wr_ready) mem[mem_wr_addr[11:0]] <= mem_wr_data;
    if (tx_valid && tx_ready) begin
      cap[cap_n % 1024] <= tx_data;
      cap_n <= cap_n + 1;
      if (tx_last) frames <= frames + 1;
    end
    if (tx_irq) irqs <= irqs + 1;
  end

  always @(negedge clk) begin
    mem_rd_ready <= stall ? (cyc % 4 != 3) : 1'b1;
    mem_wr_ready <= stall ? (cyc % 3 != 1) : 1'b1;
    tx_ready     <= stall ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int i, input int a, input int len, input int fl);
    int d = 32'h100 + 8*i;
    mem[d]   <= a[7:0];   mem[d+1] <= a[15:8];
    mem[d+2] <= a[23:16]; mem[d+3] <= a[31:24];
    mem[d+4] <= len[7:0]; mem[d+5] <= len[15:8];
    mem[d+6] <= fl[7:0];  mem[d+7] <= fl[15:8];
    @(negedge clk);
  endtask

  task automatic fill_buf(input int a, input int n, input int seed);
    for (int k = 0; k < n; k++) mem[(a + k) % 4096] <= 8'((seed * 7 + k * 13) & 8'hFF);
    @(negedge clk);
  endtask

  task automatic add_exp(input int a, input int n);
    for (int k = 0; k < n; k++) begin expb[exp_n] = mem[(a + k) % 4096]; exp_n++; end
  endtask

  function automatic int flags_at(input int i);
    return {mem[32'h100 + 8*i + 7], mem[32'h100 + 8*i + 6]};
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic kick_and_wait(input string req);
    int n = 0;
    wr_ctrl(32'h1);
    chk(idle == 1'b0, "R9 idle low after start", idle, 0);
    while (!idle && n < 20000) begin @(negedge clk); n++; end
    chk(idle == 1'b1, req, idle, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input int cap0, input int fr0, input string req);
    chk(frames == fr0 + 1, req, frames - fr0, 1);
    chk(cap_n - cap0 == exp_n, req, cap_n - cap0, exp_n);
    for (int k = 0; k < exp_n; k++)
      if (cap[(cap0 + k) % 1024] !== expb[k])
        chk(1'b0, req, cap[(cap0 + k) % 1024], expb[k]);
  endtask

  task automatic t_reset_state();
    chk(idle == 1'b1, "R9 idle at reset", idle, 1);
    chk(ring_index == 8'd0, "R10 index at reset", ring_index, 0);
    chk(tx_valid == 1'b0, "R11 no output at reset", tx_valid, 0);
    chk(tx_irq == 1'b0, "R8 no irq at reset", tx_irq, 0);
  endtask

  task automatic t_single_and_badkick();
    int c0, f0, i0;
    put_desc(0, 32'h400, 3, 16'h8821);
    put_desc(1, 32'h480, 0, 16'h0A00);
    fill_buf(32'h400, 4, 1);
    f0 = frames; i0 = irqs;
    wr_ctrl(32'h3); wr_ctrl(32'h11);
    repeat (20) @(negedge clk);
    chk(idle == 1'b1 && ring_index == 0, "R1 wrong code starts nothing", ring_index, 0);
    chk(flags_at(0) == 16'h8821, "R1 descriptor untouched", flags_at(0), 16'h8821);
    c0 = cap_n; exp_n = 0; add_exp(32'h400, 4);
    kick_and_wait("R1 walk ends");
    check_frame(c0, f0, "R6 single frame");
    chk(ring_index == 8'd1, "R2 index after one descriptor", ring_index, 1);
    chk(flags_at(0) == 16'h0021, "R5 write-back flags", flags_at(0), 16'h0021);
    chk(flags_at(1) == 16'h0A00, "R3 invalid descriptor not written", flags_at(1), 16'h0A00);
    chk(irqs == i0 + 1, "R8 irq after frame", irqs - i0, 1);
  endtask

  task automatic t_gather_wrap();
    int c0, f0, i0;
    put_desc(1, 32'h500, 5, 16'h8000);
    put_desc(2, 32'h600, 0, 16'h8400);
    put_desc(3, 32'h700, 9, 16'h8001);
    fill_buf(32'h500, 6, 2); fill_buf(32'h600, 1, 3); fill_buf(32'h700, 10, 4);
    exp_n = 0; add_exp(32'h500, 6); add_exp(32'h600, 1); add_exp(32'h700, 10);
    c0 = cap_n; f0 = frames; i0 = irqs;
    stall = 1;
    kick_and_wait("R4 gather walk ends");
    stall = 0;
    check_frame(c0, f0, "R4 gathered frame under stall R11");
    chk(ring_index == 8'd0, "R10 index wraps", ring_index, 0);
    chk(flags_at(2) == 16'h0000, "R5 error bits cleared", flags_at(2), 0);
    chk(irqs == i0 + 1, "R8 one irq", irqs - i0, 1);
  endtask

  task automatic t_empty();
    int f0 = frames, i0 = irqs;
    kick_and_wait("R3 empty walk ends");
    chk(frames == f0, "R3 no frame", frames - f0, 0);
    chk(irqs == i0, "R8 no irq without frame", irqs - i0, 0);
    chk(ring_index == 8'd0, "R3 index holds", ring_index, 0);
  endtask

  task automatic t_overflow();
    int c0, f0, i0;
    put_desc(0, 32'h800, 99, 16'h8000);
    put_desc(1, 32'h900, 99, 16'h8801);
    put_desc(2, 32'hA00, 4, 16'h8001);
    fill_buf(32'h800, 100, 5); fill_buf(32'hA00, 5, 6);
    f0 = frames; i0 = irqs;
    kick_and_wait("R7 overflow walk ends");
    chk(frames == f0, "R7 dropped frame", frames - f0, 0);
    chk(irqs == i0, "R7 no irq", irqs - i0, 0);
    chk(flags_at(1) == 16'h6001, "R7 overflow flags", flags_at(1), 16'h6001);
    chk(ring_index == 8'd2, "R7 index past overflow", ring_index, 2);
    exp_n = 0; add_exp(32'hA00, 5); c0 = cap_n;
    kick_and_wait("R7 follow-up walk ends");
    check_frame(c0, f0, "R7 fill level reset");
  endtask

  task automatic t_bound_and_clear();
    int c0, f0, i0;
    wr_ctrl(32'h4);
    chk(ring_index == 8'd0, "R9 reset bit clears index", ring_index, 0);
    ring_size = 8'd3;
    put_desc(0, 32'hB00, 1, 16'h8000);
    put_desc(1, 32'hB10, 1, 16'h8000);
    put_desc(2, 32'hB20, 1, 16'h8000);
    f0 = frames; i0 = irqs;
    kick_and_wait("R10 bounded walk ends");
    chk(ring_index == 8'd0, "R10 walked whole ring once", ring_index, 0);
    chk(flags_at(2) == 16'h0000, "R10 last ring entry processed", flags_at(2), 0);
    chk(frames == f0 && irqs == i0, "R10 no frame", frames - f0, 0);
    wr_ctrl(32'h4);
    put_desc(0, 32'hC00, 2, 16'h8001);
    fill_buf(32'hC00, 3, 7);
    exp_n = 0; add_exp(32'hC00, 3); c0 = cap_n;
    kick_and_wait("R9 walk after clear ends");
    check_frame(c0, f0, "R9 reset bit clears fill level");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] <= 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_and_badkick();
    t_gather_wrap();
    t_empty();
    t_overflow();
    t_bound_and_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule